// File: doc/BRIEF.md
# Paired Register Move Unit

This block performs the two paired register transfers used around function calls: the forward transfer copies two callee-saved registers into the two argument registers, and the reverse transfer copies the two argument registers into two callee-saved registers. Each transfer reads both of its source values and writes both of its destination values on the same clock edge. No intermediate state, with only one of the two registers updated, can ever be seen from the register file.

A decoded operation arrives as a valid strobe, a direction bit and two 3-bit selectors. Each selector names one of eight callee-saved registers. The block holds its own 32-entry register file. A general write port stands in for the rest of the pipeline's writeback. A registered read port lets the surrounding logic observe any register. A legal operation is answered one cycle later by a done pulse. A reverse transfer whose two selectors are equal is rejected: it writes nothing and raises an illegal pulse in place of done.

Top module: `regpair_mover`

## Requirements
- R1: After synchronous reset, `done`, `illegal` and `rd_data` are zero and every register reads as zero.
- R2: With `op_kind` = 0 (forward), the edge that samples `op_valid` writes register 10 with the saved register named by `sel_first` and register 11 with the one named by `sel_second`, using the values held before that edge.
- R3: A forward transfer with `sel_first` equal to `sel_second` is legal and writes the same value to registers 10 and 11.
- R4: With `op_kind` = 1 (reverse), the edge that samples `op_valid` writes the old value of register 10 into the saved register named by `sel_first`, and the old value of register 11 into the one named by `sel_second`.
- R5: A reverse transfer with equal selectors changes no register and pulses `illegal` instead of `done`.
- R6: Selector value 0 names register 8 and value 1 names register 9. Values 2 through 7 name registers 18 through 23.
- R7: Both writes of a transfer appear together one edge after the operation is sampled. A transfer issued in the very next cycle already sees both results.
- R8: `done` (legal) or `illegal` (rejected) is high for exactly the cycle after each cycle in which `op_valid` is sampled high. Both are low after a cycle without `op_valid`, and they are never high together.
- R9: The general write port (`wr_en`, `wr_addr`, `wr_data`) updates one register per edge. Writes to register 0 are ignored and register 0 reads as zero. When a transfer writes the same register on the same edge, the transfer's value wins.
- R10: `rd_data` shows the register named by `rd_addr` one edge after `rd_addr` is presented, and holds its previous value until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Transfer request strobe |
| op_kind | input | 1 | 0 = saved pair to argument pair, 1 = argument pair to saved pair |
| sel_first | input | 3 | Saved-register selector paired with register 10 |
| sel_second | input | 3 | Saved-register selector paired with register 11 |
| wr_en | input | 1 | General write enable |
| wr_addr | input | 5 | General write register index |
| wr_data | input | 32 | General write value |
| rd_addr | input | 5 | Read register index |
| rd_data | output | 32 | Registered read value |
| done | output | 1 | Pulse: transfer accepted and committed |
| illegal | output | 1 | Pulse: transfer rejected |

## Verification
The bench aims at the aliasing rule. If equal reverse selectors were not rejected, one saved register would be written twice and `illegal` would never rise. If equal forward selectors were wrongly refused, the argument registers would keep stale data. Every selector value is driven through a forward transfer, so an off-by-one in the mapping of the upper six selectors shows up as the wrong value in register 10. Back-to-back forward and reverse transfers expose a design that commits its two writes on different edges or reads sources after writing. A collision test expose a general write that overrides a transfer, and writes to register 0 expose a register 0 that can be written.

// File: rtl/regpair_pkg.sv
package regpair_pkg;
  typedef enum logic {
    MV_TO_ARGS  = 1'b0,
    MV_TO_SAVED = 1'b1
  } mv_kind_e;

  localparam logic [4:0] ARG_LO_IDX = 5'd10;
  localparam logic [4:0] ARG_HI_IDX = 5'd11;

  // Map a 3-bit saved-register selector onto a register index.
  function automatic logic [4:0] saved_index(input logic [2:0] sel);
    if (sel < 3'd2) saved_index = 5'd8 + {2'b00, sel};
    else            saved_index = 5'd16 + {2'b00, sel};
  endfunction
endpackage

// File: rtl/regpair_decode.sv
module regpair_decode
  import regpair_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          op_valid,
  input  logic          op_kind,
  input  logic [2:0]    sel_first,
  input  logic [2:0]    sel_second,
  output logic [AW-1:0] src_lo,
  output logic [AW-1:0] src_hi,
  output logic [AW-1:0] dst_lo,
  output logic [AW-1:0] dst_hi,
  output logic          accept,
  output logic          reject
);
  logic alias_bad;

  always_comb begin
    if (op_kind == MV_TO_SAVED) begin
      src_lo = ARG_LO_IDX;
      src_hi = ARG_HI_IDX;
      dst_lo = saved_index(sel_first);
      dst_hi = saved_index(sel_second);
    end else begin
      src_lo = saved_index(sel_first);
      src_hi = saved_index(sel_second);
      dst_lo = ARG_LO_IDX;
      dst_hi = ARG_HI_IDX;
    end
  end

  assign alias_bad = (op_kind == MV_TO_SAVED) && (sel_first == sel_second);
  assign accept    = op_valid && !alias_bad;
  assign reject    = op_valid && alias_bad;
endmodule

// File: rtl/regpair_regfile.sv
module regpair_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pw_en,
  input  logic [AW-1:0]              pw_addr_lo,
  input  logic [XLEN-1:0]            pw_data_lo,
  input  logic [AW-1:0]              pw_addr_hi,
  input  logic [XLEN-1:0]            pw_data_hi,
  input  logic                       gw_en,
  input  logic [AW-1:0]              gw_addr,
  input  logic [XLEN-1:0]            gw_data,
  input  logic [AW-1:0]              pr_addr_lo,
  output logic [XLEN-1:0]            pr_data_lo,
  input  logic [AW-1:0]              pr_addr_hi,
  output logic [XLEN-1:0]            pr_data_hi,
  input  logic [AW-1:0]              rr_addr,
  output logic [XLEN-1:0]            rr_data,
  output logic [NREG-1:0][XLEN-1:0]  rf_view
);
  logic [NREG-1:0][XLEN-1:0] regs_q;

  assign regs_q[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)                                    regs_q[i] <= '0;
      else if (pw_en && pw_addr_lo == AW'(i))     regs_q[i] <= pw_data_lo;
      else if (pw_en && pw_addr_hi == AW'(i))     regs_q[i] <= pw_data_hi;
      else if (gw_en && gw_addr == AW'(i))        regs_q[i] <= gw_data;
    end
  end

  assign pr_data_lo = regs_q[pr_addr_lo];
  assign pr_data_hi = regs_q[pr_addr_hi];
  assign rf_view    = regs_q;

  always_ff @(posedge clk) begin
    if (rst) rr_data <= '0;
    else     rr_data <= regs_q[rr_addr];
  end
endmodule

// File: rtl/regpair_mover.sv
module regpair_mover #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic            op_kind,
  input  logic [2:0]      sel_first,
  input  logic [2:0]      sel_second,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [XLEN-1:0] rd_data,
  output logic            done,
  output logic            illegal
);
  logic [AW-1:0]             src_lo, src_hi, dst_lo, dst_hi;
  logic                      accept, reject;
  logic [XLEN-1:0]           val_lo, val_hi;
  logic [NREG-1:0][XLEN-1:0] rf_view;

  regpair_decode #(.AW(AW)) u_dec (
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .sel_first (sel_first),
    .sel_second(sel_second),
    .src_lo    (src_lo),
    .src_hi    (src_hi),
    .dst_lo    (dst_lo),
    .dst_hi    (dst_hi),
    .accept    (accept),
    .reject    (reject)
  );

  regpair_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .pw_en     (accept),
    .pw_addr_lo(dst_lo),
    .pw_data_lo(val_lo),
    .pw_addr_hi(dst_hi),
    .pw_data_hi(val_hi),
    .gw_en     (wr_en),
    .gw_addr   (wr_addr),
    .gw_data   (wr_data),
    .pr_addr_lo(src_lo),
    .pr_data_lo(val_lo),
    .pr_addr_hi(src_hi),
    .pr_data_hi(val_hi),
    .rr_addr   (rd_addr),
    .rr_data   (rd_data),
    .rf_view   (rf_view)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= accept;
      illegal <= reject;
    end
  end
endmodule

// File: rtl/regpair_mover_chk.sv
module regpair_mover_chk
  import regpair_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      op_valid,
  input logic                      op_kind,
  input logic [2:0]                sel_first,
  input logic [2:0]                sel_second,
  input logic                      wr_en,
  input logic                      done,
  input logic                      illegal,
  input logic [NREG-1:0][XLEN-1:0] rf_view
);
  logic [4:0]      idx_a, idx_b;
  logic [XLEN-1:0] sv_a, sv_b, arg_lo, arg_hi;

  assign idx_a  = saved_index(sel_first);
  assign idx_b  = saved_index(sel_second);
  assign sv_a   = rf_view[idx_a];
  assign sv_b   = rf_view[idx_b];
  assign arg_lo = rf_view[ARG_LO_IDX];
  assign arg_hi = rf_view[ARG_HI_IDX];

  // R2 / R3 / R7: both argument registers take the old saved values together
  a_r2_forward_pair: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == MV_TO_ARGS) |=>
      (arg_lo == $past(sv_a) && arg_hi == $past(sv_b)));

  // R4 / R7: both saved registers take the old argument values together
  a_r4_reverse_pair: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == MV_TO_SAVED && sel_first != sel_second) |=>
      (rf_view[$past(idx_a)] == $past(arg_lo) && rf_view[$past(idx_b)] == $past(arg_hi)));

  // R5: rejected transfer leaves the whole register file untouched
  a_r5_alias_rejected: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == MV_TO_SAVED && sel_first == sel_second && !wr_en) |=>
      (illegal && !done && rf_view == $past(rf_view)));

  // R8: every sampled request gets exactly one response
  a_r8_response: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> $onehot({done, illegal}));

  a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!done && !illegal));

  // R9: register 0 stays zero
  a_r9_zero_reg: assert property (@(posedge clk) disable iff (rst)
    rf_view[0] == '0);
endmodule

bind regpair_mover regpair_mover_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .op_kind   (op_kind),
  .sel_first (sel_first),
  .sel_second(sel_second),
  .wr_en     (wr_en),
  .done      (done),
  .illegal   (illegal),
  .rf_view   (rf_view)
);

// File: tb/tb_regpair_mover.sv
module tb_regpair_mover;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid, op_kind;
  logic [2:0]  sel_first, sel_second;
  logic        wr_en;
  logic [4:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        done, illegal;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  regpair_mover dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .sel_first(sel_first), .sel_second(sel_second),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .illegal(illegal)
  );

  function automatic logic [4:0] sidx(input logic [2:0] s);
    case (s)
      3'd0: sidx = 5'd8;   3'd1: sidx = 5'd9;
      3'd2: sidx = 5'd18;  3'd3: sidx = 5'd19;
      3'd4: sidx = 5'd20;  3'd5: sidx = 5'd21;
      3'd6: sidx = 5'd22;  default: sidx = 5'd23;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  // Issue one transfer; returns {done, illegal} seen in the following cycle.
  task automatic op(input logic k, input logic [2:0] s1, input logic [2:0] s2,
                    output logic [1:0] resp);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; sel_first = s1; sel_second = s2;
    @(negedge clk);
    op_valid = 1'b0;
    resp = {done, illegal};
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 illegal", {31'b0, illegal}, 32'd0);
    check("R1 rd_data", rd_data, 32'd0);
    rd(5'd10, v); check("R1 x10", v, 32'd0);
    rd(5'd21, v); check("R1 x21", v, 32'd0);
  endtask

  task automatic t_forward();
    logic [31:0] v; logic [1:0] r;
    wr(5'd8, 32'hA0A0_0001);
    wr(5'd19, 32'hB0B0_0002);
    op(1'b0, 3'd0, 3'd3, r);
    check("R2 done", {30'b0, r}, 32'd2);
    rd(5'd10, v); check("R2 x10", v, 32'hA0A0_0001);
    rd(5'd11, v); check("R2 x11", v, 32'hB0B0_0002);
    rd(5'd8, v);  check("R2 source kept", v, 32'hA0A0_0001);
  endtask

  task automatic t_forward_same();
    logic [31:0] v; logic [1:0] r;
    wr(5'd23, 32'hC0DE_0007);
    op(1'b0, 3'd7, 3'd7, r);
    check("R3 done", {30'b0, r}, 32'd2);
    rd(5'd10, v); check("R3 x10", v, 32'hC0DE_0007);
    rd(5'd11, v); check("R3 x11", v, 32'hC0DE_0007);
  endtask

  task automatic t_reverse();
    logic [31:0] v; logic [1:0] r;
    wr(5'd10, 32'hD00D_1111);
    wr(5'd11, 32'hE00E_2222);
    op(1'b1, 3'd1, 3'd5, r);
    check("R4 done", {30'b0, r}, 32'd2);
    rd(5'd9, v);  check("R4 x9", v, 32'hD00D_1111);
    rd(5'd21, v); check("R4 x21", v, 32'hE00E_2222);
  endtask

  task automatic t_reverse_alias();
    logic [31:0] v; logic [1:0] r;
    wr(5'd18, 32'hF00F_3333);
    op(1'b1, 3'd2, 3'd2, r);
    check("R5 illegal pulse", {30'b0, r}, 32'd1);
    rd(5'd18, v); check("R5 x18 unchanged", v, 32'hF00F_3333);
    rd(5'd10, v); check("R5 x10 unchanged", v, 32'hD00D_1111);
    check("R5 illegal cleared", {31'b0, illegal}, 32'd0);
  endtask

  task automatic t_map();
    logic [31:0] v; logic [1:0] r;
    for (int s = 0; s < 8; s++) wr(sidx(3'(s)), 32'h5E10_0000 + 32'(s));
    for (int s = 0; s < 8; s++) begin
      op(1'b0, 3'(s), 3'(7 - s), r);
      rd(5'd10, v); check("R6 map first", v, 32'h5E10_0000 + 32'(s));
      rd(5'd11, v); check("R6 map second", v, 32'h5E10_0000 + 32'(7 - s));
    end
  endtask

  task automatic t_chain();
    logic [31:0] v; logic d1, d2, d3;
    wr(5'd8, 32'h1111_AAAA);
    wr(5'd9, 32'h2222_BBBB);
    @(negedge clk);
    op_valid = 1'b1; op_kind = 1'b0; sel_first = 3'd0; sel_second = 3'd1;
    @(negedge clk);
    d1 = done;
    op_kind = 1'b1; sel_first = 3'd6; sel_second = 3'd4;
    @(negedge clk);
    d2 = done;
    op_valid = 1'b0;
    @(negedge clk);
    d3 = done;
    check("R8 done first", {31'b0, d1}, 32'd1);
    check("R8 done second", {31'b0, d2}, 32'd1);
    check("R8 done drops", {31'b0, d3}, 32'd0);
    rd(5'd22, v); check("R7 x22 from new a0", v, 32'h1111_AAAA);
    rd(5'd20, v); check("R7 x20 from new a1", v, 32'h2222_BBBB);
  endtask

  task automatic t_gen_write();
    logic [31:0] v; logic [1:0] r;
    wr(5'd0, 32'hDEAD_BEEF);
    rd(5'd0, v); check("R9 x0 zero", v, 32'd0);
    wr(5'd19, 32'h7777_0019);
    wr(5'd8, 32'h7777_0008);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd10; wr_data = 32'h0BAD_0BAD;
    op_valid = 1'b1; op_kind = 1'b0; sel_first = 3'd3; sel_second = 3'd0;
    @(negedge clk);
    wr_en = 1'b0; op_valid = 1'b0;
    r = {done, illegal};
    check("R9 collision done", {30'b0, r}, 32'd2);
    rd(5'd10, v); check("R9 transfer wins", v, 32'h7777_0019);
    rd(5'd11, v); check("R9 other dest", v, 32'h7777_0008);
  endtask

  task automatic t_read_latency();
    logic [31:0] v;
    rd(5'd8, v);
    check("R10 first read", v, 32'h7777_0008);
    @(negedge clk);
    rd_addr = 5'd19;
    #1;
    check("R10 held before edge", rd_data, 32'h7777_0008);
    @(negedge clk);
    check("R10 after edge", rd_data, 32'h7777_0019);
  endtask

  initial begin
    #4_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_kind = 1'b0; sel_first = '0; sel_second = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_forward();
    t_forward_same();
    t_reverse();
    t_reverse_alias();
    t_map();
    t_chain();
    t_gen_write();
    t_read_latency();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule